// File: doc/BRIEF.md
# Bidirectional Accumulator Shift Unit

This execution unit sits in the datapath of a DSP that uses 16-bit instructions. It holds two 40-bit accumulators and carries out four shift instructions. Each instruction moves one accumulator left or right by a signed 16-bit count read from a register. A positive count shifts left and a negative count shifts right by its magnitude.

The count comes from one of two places. Two of the forms read the high word of one of the two auxiliary registers, and an opcode bit picks which one. The other two forms read the middle word of the accumulator that is not being shifted. For each source there is a logical form, which treats the accumulator as unsigned, and an arithmetic form, which treats it as signed. The result is written back to the destination accumulator at the next clock edge. Zero and sign flags are updated at the same edge.

A separate write port loads either accumulator directly. The processor uses it to move operands in.

Top module: `acc_shift_unit`

## Requirements
- R1: An instruction executes only when `op_valid` is high, `opcode[15:12]` is 4'b0011, `opcode[7]` is 1 and `opcode[11:10]` is not 2'b00. Any other opcode, or a matching opcode with `op_valid` low, leaves both accumulators and both flags unchanged.
- R2: `opcode[8]` selects the destination accumulator (0 selects `acc0`, 1 selects `acc1`). When `opcode[11:10]` is 01 (logical) or 10 (arithmetic), the count is `aux_hi1` if `opcode[9]` is 1 and `aux_hi0` otherwise.
- R3: When `opcode[11:10]` is 11, the count is bits [31:16] of the non-destination accumulator. `opcode[9]` then chooses the variant: 0 is logical and 1 is arithmetic.
- R4: The count is read as a two's-complement 16-bit value. A positive count shifts left, a negative count shifts right by its magnitude, and a zero count writes the accumulator back unchanged.
- R5: Left shifts bring zeros in at bit 0 and drop bits above bit 39. Logical right shifts bring zeros in at bit 39.
- R6: Arithmetic right shifts copy bit 39 into every vacated bit.
- R7: When the count magnitude is 40 or more (up to 32768 for count 16'h8000), left shifts and logical right shifts give zero, and arithmetic right shifts give 40 copies of bit 39.
- R8: At the edge that writes the result, `flag_zero` becomes 1 exactly when the 40-bit result is zero, and `flag_sign` becomes bit 39 of the result. The flags hold their value in every cycle in which no instruction executes.
- R9: An instruction completes in one clock. The non-destination accumulator is unchanged, and `opcode[6:0]` has no effect on the result.
- R10: When no instruction executes, `acc_wr_en` loads `acc_wr_data` into the accumulator chosen by `acc_wr_sel` (0 selects `acc0`, 1 selects `acc1`) and leaves the flags alone. In a cycle where an instruction executes, the write port is ignored.
- R11: While `rst_n` is low, both accumulators are 0, `flag_zero` is 1 and `flag_sign` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_valid | input | 1 | Opcode strobe |
| opcode | input | 16 | Instruction word |
| aux_hi0 | input | 16 | High word of auxiliary register 0 |
| aux_hi1 | input | 16 | High word of auxiliary register 1 |
| acc_wr_en | input | 1 | Direct accumulator load enable |
| acc_wr_sel | input | 1 | Accumulator chosen for the direct load |
| acc_wr_data | input | 40 | Direct load value |
| acc0 | output | 40 | Accumulator 0 |
| acc1 | output | 40 | Accumulator 1 |
| flag_zero | output | 1 | Result-is-zero flag |
| flag_sign | output | 1 | Bit 39 of the last result |

## Verification
The bench builds the unit with its default parameters: 40-bit accumulators and 16-bit words. With these values the whole signed count range can be reached, including the one negative count, 16'h8000, whose magnitude has no positive 16-bit counterpart. The sweep covers every count from -45 to +45, which crosses the 40-bit boundary in both directions, plus extreme counts. It runs each count through all four forms, both destinations and both auxiliary sources. The accumulator patterns include negative, positive and single-bit values, and the extension bits are random. Each result is compared with a shift computed arithmetically in the bench.

// File: rtl/acc_shift_unit.sv
module acc_shift_unit #(
  parameter int ACC_W  = 40,
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic [15:0]       opcode,
  input  logic [WORD_W-1:0] aux_hi0,
  input  logic [WORD_W-1:0] aux_hi1,
  input  logic              acc_wr_en,
  input  logic              acc_wr_sel,
  input  logic [ACC_W-1:0]  acc_wr_data,
  output logic [ACC_W-1:0]  acc0,
  output logic [ACC_W-1:0]  acc1,
  output logic              flag_zero,
  output logic              flag_sign
);
  localparam int MID_LO = WORD_W;
  localparam int MID_HI = 2 * WORD_W - 1;
  localparam int MAG_W  = WORD_W + 1;
  localparam int SH_W   = $clog2(ACC_W + 1);

  logic [1:0] kind;
  logic exec, use_mid, arith, dst, neg, big;
  logic [WORD_W-1:0] cnt;
  logic [MAG_W-1:0]  mag;
  logic [SH_W-1:0]   amt;
  logic [ACC_W-1:0]  src_acc, res;

  assign kind    = opcode[11:10];
  assign exec    = op_valid && opcode[15:12] == 4'b0011 && opcode[7] && kind != 2'b00;
  assign use_mid = kind == 2'b11;
  assign arith   = kind == 2'b10 || (use_mid && opcode[9]);
  assign dst     = opcode[8];
  assign src_acc = dst ? acc1 : acc0;

  assign cnt = use_mid ? (dst ? acc0[MID_HI:MID_LO] : acc1[MID_HI:MID_LO])
                       : (opcode[9] ? aux_hi1 : aux_hi0);
  assign neg = cnt[WORD_W-1];
  assign mag = neg ? ((MAG_W'(1) << WORD_W) - {1'b0, cnt}) : {1'b0, cnt};
  assign big = mag >= MAG_W'(ACC_W);
  assign amt = mag[SH_W-1:0];

  always_comb begin
    if (cnt == '0)
      res = src_acc;
    else if (!neg)
      res = big ? '0 : src_acc << amt;
    else if (arith)
      res = big ? {ACC_W{src_acc[ACC_W-1]}} : ACC_W'($signed(src_acc) >>> amt);
    else
      res = big ? '0 : src_acc >> amt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc0      <= '0;
      acc1      <= '0;
      flag_zero <= 1'b1;
      flag_sign <= 1'b0;
    end else if (exec) begin
      if (dst) acc1 <= res;
      else     acc0 <= res;
      flag_zero <= res == '0;
      flag_sign <= res[ACC_W-1];
    end else if (acc_wr_en) begin
      if (acc_wr_sel) acc1 <= acc_wr_data;
      else            acc0 <= acc_wr_data;
    end
  end

  assert_idle_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !exec && !acc_wr_en |=> $stable(acc0) && $stable(acc1) && $stable(flag_zero) && $stable(flag_sign));

  assert_zero_count_R4: assert property (@(posedge clk) disable iff (!rst_n)
    exec && cnt == '0 |=> ($past(dst) ? acc1 : acc0) == $past(src_acc));

  assert_big_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    exec && big && !(arith && neg) |=> ($past(dst) ? acc1 : acc0) == '0);

  assert_big_fill_R7: assert property (@(posedge clk) disable iff (!rst_n)
    exec && big && arith && neg |=> ($past(dst) ? acc1 : acc0) == {ACC_W{$past(src_acc[ACC_W-1])}});

  assert_flag_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    exec |=> flag_zero == (($past(dst) ? acc1 : acc0) == '0));

  assert_flag_sign_R8: assert property (@(posedge clk) disable iff (!rst_n)
    exec |=> flag_sign == ($past(dst) ? acc1[ACC_W-1] : acc0[ACC_W-1]));

  assert_other_kept_R9: assert property (@(posedge clk) disable iff (!rst_n)
    exec |=> ($past(dst) ? acc0 == $past(acc0) : acc1 == $past(acc1)));

  assert_flags_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !exec |=> $stable(flag_zero) && $stable(flag_sign));
endmodule

// File: tb/acc_shift_unit_bench.sv
`timescale 1ns/1ps
module acc_shift_unit_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic op_valid = 1'b0, acc_wr_en = 1'b0, acc_wr_sel = 1'b0;
  logic [15:0] opcode = '0, aux_hi0 = '0, aux_hi1 = '0;
  logic [39:0] acc_wr_data = '0;
  logic [39:0] acc0, acc1;
  logic flag_zero, flag_sign;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  acc_shift_unit u_acc_shift_unit (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .opcode(opcode),
    .aux_hi0(aux_hi0), .aux_hi1(aux_hi1), .acc_wr_en(acc_wr_en),
    .acc_wr_sel(acc_wr_sel), .acc_wr_data(acc_wr_data),
    .acc0(acc0), .acc1(acc1), .flag_zero(flag_zero), .flag_sign(flag_sign));

  task automatic chk(input bit ok, input string tag, input logic [39:0] act, input logic [39:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [39:0] model(input logic [39:0] a, input logic signed [15:0] c, input bit ar);
    longint m;
    longint sa;
    if (c == 0) return a;
    if (c > 0) begin
      if (c >= 40) return '0;
      return 40'(64'(a) << c);
    end
    m = -longint'(c);
    if (m >= 40) return (ar && a[39]) ? {40{1'b1}} : '0;
    if (!ar) return 40'(64'(a) >> m);
    sa = longint'({{24{a[39]}}, a});
    return 40'(sa >>> m);
  endfunction

  task automatic load(input bit sel, input logic [39:0] v);
    acc_wr_en = 1'b1; acc_wr_sel = sel; acc_wr_data = v;
    @(negedge clk);
    acc_wr_en = 1'b0;
  endtask

  function automatic logic [15:0] mk_op(input int form, input bit d, input bit s, input logic [6:0] ext);
    logic [1:0] k;
    bit b9;
    k  = (form == 0) ? 2'b01 : (form == 1) ? 2'b10 : 2'b11;
    b9 = (form < 2) ? s : (form == 3);
    return {4'b0011, k, b9, d, 1'b1, ext};
  endfunction

  task automatic run_op(input int form, input bit d, input bit s, input logic [39:0] a,
                        input logic [39:0] o, input logic signed [15:0] c);
    logic [39:0] other, exp, got, oth;
    bit ar;
    string tag;
    other = (form >= 2) ? {o[39:32], c, o[15:0]} : o;
    load(d, a);
    load(!d, other);
    aux_hi0 = s ? ~c : c;
    aux_hi1 = s ? c : ~c;
    ar = (form == 1 || form == 3);
    exp = model(a, c, ar);
    op_valid = 1'b1;
    opcode = mk_op(form, d, s, 7'($urandom));
    @(negedge clk);
    op_valid = 1'b0;
    got = d ? acc1 : acc0;
    oth = d ? acc0 : acc1;
    if (c == 0) tag = "R4";
    else if (c >= 40 || c <= -40) tag = "R7";
    else if (c > 0) tag = "R5";
    else tag = ar ? "R6" : "R5";
    chk(got == exp, $sformatf("%s %s R2 R9 form%0d d%0d s%0d cnt=%0d", tag,
        (form >= 2) ? "R3" : "R1", form, d, s, c), got, exp);
    chk(oth == other, "R9 other accumulator", oth, other);
    chk(flag_zero == (exp == 0) && flag_sign == exp[39], "R8 flags",
        {38'b0, flag_zero, flag_sign}, {38'b0, exp == 0, exp[39]});
  endtask

  function automatic logic signed [15:0] count_at(input int i);
    if (i < 91) return 16'(i - 45);
    case (i)
      91: return 16'sh7FFF;
      92: return 16'sh8000;
      93: return 16'sh8001;
      94: return 16'sd100;
      default: return -16'sd1000;
    endcase
  endfunction

  function automatic logic [39:0] pat(input int p);
    case (p)
      0: return 40'h80_1234_5678;
      1: return 40'h7F_FEDC_BA98;
      2: return 40'h00_0000_0001;
      default: return {8'($urandom), 32'($urandom)};
    endcase
  endfunction

  initial begin
    #800000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [39:0] s0, s1;
    logic fz, fs;
    repeat (3) @(negedge clk);
    chk(acc0 == 0 && acc1 == 0, "R11 reset accumulators", acc0 | acc1, '0);
    chk(flag_zero == 1 && flag_sign == 0, "R11 reset flags", {38'b0, flag_zero, flag_sign}, 40'h2);
    rst_n = 1'b1;
    @(negedge clk);

    load(1'b0, 40'h12_3456_789A);
    load(1'b1, 40'hF0_0003_0000);
    chk(acc0 == 40'h12_3456_789A && acc1 == 40'hF0_0003_0000, "R10 direct load", acc0, 40'h12_3456_789A);
    chk(flag_zero == 1 && flag_sign == 0, "R10 load leaves flags", {38'b0, flag_zero, flag_sign}, 40'h2);

    for (int form = 0; form < 4; form++)
      for (int d = 0; d < 2; d++)
        for (int s = 0; s < 2; s++)
          for (int p = 0; p < 4; p++)
            for (int i = 0; i < 96; i++)
              run_op(form, d[0], s[0], pat(p), pat(3 - p), count_at(i));

    s0 = acc0; s1 = acc1; fz = flag_zero; fs = flag_sign;
    aux_hi0 = 16'd3; aux_hi1 = 16'd5;
    op_valid = 1'b0; opcode = 16'h3480;
    @(negedge clk);
    chk(acc0 == s0 && acc1 == s1 && flag_zero == fz && flag_sign == fs, "R1 valid low", acc0, s0);
    op_valid = 1'b1;
    for (int k = 0; k < 4; k++) begin
      case (k)
        0: opcode = 16'h3080;
        1: opcode = 16'h3400;
        2: opcode = 16'h2480;
        default: opcode = 16'h7780;
      endcase
      @(negedge clk);
      chk(acc0 == s0 && acc1 == s1 && flag_zero == fz && flag_sign == fs,
          $sformatf("R1 non-matching opcode %h", opcode), acc0, s0);
    end
    op_valid = 1'b0;

    load(1'b0, 40'h00_0000_0011);
    aux_hi0 = 16'd4;
    op_valid = 1'b1; opcode = 16'h3480;
    acc_wr_en = 1'b1; acc_wr_sel = 1'b0; acc_wr_data = 40'hAA_AAAA_AAAA;
    @(negedge clk);
    op_valid = 1'b0; acc_wr_en = 1'b0;
    chk(acc0 == 40'h00_0000_0110, "R10 write ignored during op", acc0, 40'h00_0000_0110);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule